// File: doc/BRIEF.md
# Dual-Link Seven-to-One Pixel Deserializer

This block sits in a flat-panel receive path behind the analog line receivers and the bit-clock generator. It takes two serial pixel links, each made of four data lanes plus a frame-clock lane, all sampled by one bit clock that runs at seven times the frame rate and is already phase-aligned. From every frame of seven bit slots it rebuilds a 24-bit colour pixel with its data-enable and sync flags. It drives two parallel pixel ports, a shared control group, a pixel strobe for one bit clock per output word, and a pixel clock whose launch edge can be chosen.

A two-bit mode input picks how the links are used. In dual-link operation link 1 feeds port 1 and link 2 feeds port 2, one output word per frame. In single-link operation link 2 is ignored and successive pixels from link 1 are paired, the earlier one on port 1 and the later one on port 2, so output words come at half the frame rate. The upper mode bit arms a fail-safe watchdog: when the frame clock stops, the output enable drops so that the pad drivers go high-impedance, and it comes back with the next complete frame.

A small state machine steers the output. Its states are SYNC (waiting for the first complete frame after reset or a mode change), DUAL (one word per frame), PAIR_LO (waiting for the first pixel of a pair), PAIR_HI (holding the first pixel, waiting for the second) and LOST (fail-safe tripped). Its transitions are: any state to SYNC on a mode change; any state other than LOST to LOST on a watchdog trip in a fail-safe mode; SYNC or LOST to DUAL on a frame in dual-link operation; SYNC, LOST or PAIR_LO to PAIR_HI on a frame in single-link operation; PAIR_HI to PAIR_LO when a pair completes. PAIR_HI stays in PAIR_HI when a data-enable rise makes the new frame the first pixel of a pair.

Top module: `pxl_deser`

## Requirements
- R1: A frame starts at the bit-clock sample where a link's frame-clock lane is 1 after being 0 on the previous sample. That sample and the next six carry lane bit positions 6, 5, 4, 3, 2, 1, 0 in that order. The frame-clock lane is driven high for slots 6 to 3 and low for slots 2 to 0.
- R2: Lane bits map to the pixel as follows, with data lane A on input bit 0, B on bit 1, C on bit 2 and D on bit 3. A[5:0]=R[5:0] and A[6]=G[0]. B[4:0]=G[5:1] and B[6:5]=B[1:0]. C[3:0]=B[5:2], C[4]=HSYNC, C[5]=VSYNC and C[6]=DE. D[1:0]=R[7:6], D[3:2]=G[7:6] and D[5:4]=B[7:6]. D[6] is unused.
- R3: With mode_i[0]=0 (00 dual, 10 dual fail-safe), every complete link-1 frame produces one strobe. Port 1 then carries the link-1 pixel, port 2 the link-2 pixel of the same frame, and DE/HSYNC/VSYNC come from link 1. Back-to-back frames give strobes 7 bit clocks apart.
- R4: With mode_i[0]=1 (01 single, 11 single fail-safe), link-2 inputs have no effect. Link-1 pixels are paired: port 1 gets the earlier pixel, port 2 the later one, and DE/HSYNC/VSYNC come from the earlier one. The pair is strobed once its second pixel is captured, and back-to-back pairs give strobes 14 bit clocks apart.
- R5: In single-link operation a pixel with DE=1 that follows a pixel with DE=0 always becomes the first pixel of a new pair. A held pixel with DE=0 is dropped in that case.
- R6: pix_clk_o equals edge_sel_i (1 = rising launch, 0 = falling launch) in every strobe cycle and for the first 4 (dual) or 7 (single) bit clocks of each output period. It holds the complement otherwise, so it has the complement in the cycle before each strobe.
- R7: Between strobes the pixel ports, HSYNC and VSYNC hold their values, and DE may only fall.
- R8: A change of mode_i drives de_o low on the next bit clock and discards input until a complete frame starting after the change has been assembled.
- R9: When mode_i[1]=1 and no frame-clock rising edge is seen for 16 bit clocks, out_en_o falls (high-impedance request). Edges on link 1 always count, and edges on link 2 count in dual-link modes.
- R10: After a fail-safe trip, the next complete frame sets out_en_o again. Strobes occur only while out_en_o is 1.
- R11: When mode_i[1]=0, out_en_o is 1 on every bit clock.
- R12: After reset all pixel, control and strobe outputs are 0 and out_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven per frame |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Bit 0: single-link; bit 1: fail-safe armed |
| edge_sel_i | input | 1 | Pixel-clock launch edge, 1 rising, 0 falling |
| l1_data_i | input | 4 | Link 1 data lanes A..D on bits 0..3 |
| l1_fclk_i | input | 1 | Link 1 frame-clock lane |
| l2_data_i | input | 4 | Link 2 data lanes A..D on bits 0..3 |
| l2_fclk_i | input | 1 | Link 2 frame-clock lane |
| p1_r_o | output | 8 | Port 1 red |
| p1_g_o | output | 8 | Port 1 green |
| p1_b_o | output | 8 | Port 1 blue |
| p2_r_o | output | 8 | Port 2 red |
| p2_g_o | output | 8 | Port 2 green |
| p2_b_o | output | 8 | Port 2 blue |
| de_o | output | 1 | Data enable |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| pix_clk_o | output | 1 | Output pixel clock |
| pix_stb_o | output | 1 | One-cycle strobe per new output word |
| out_en_o | output | 1 | Output-driver enable; 0 asks for high-impedance |

## Verification
The bound checker watches on every cycle that the pixel clock sits at the launch level when a strobe fires, and that the outputs hold between strobes with DE only allowed to fall. On every cycle it also checks that a mode change pulls DE low, that the enable stays on outside fail-safe modes, that a long frame-clock gap turns the enable off, and that no strobe fires while the enable is off. The lane bit map, the pairing order, the DE-rise realignment, the fact that link 2 has no effect in single-link mode, and the 7 and 14 bit-clock strobe spacing can only be shown by the bench. Its scoreboard encodes known pixels onto the lanes and compares every strobed word.

// File: rtl/pxl_deser_pkg.sv
package pxl_deser_pkg;

    localparam int LANES   = 4;
    localparam int BITS    = 7;
    localparam int WORD_W  = LANES * BITS;
    localparam int COLOR_W = 8;

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_DUAL,
        ST_PAIR_LO,
        ST_PAIR_HI,
        ST_LOST
    } dsr_state_e;

    typedef struct packed {
        logic               de;
        logic               vs;
        logic               hs;
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } pixel_t;

    // Lane word layout: lane k occupies bits [k*BITS +: BITS], bit 6 first on the wire.
    function automatic pixel_t unpack_word(input logic [WORD_W-1:0] w);
        pixel_t             p;
        logic [BITS-1:0]    la, lb, lc, ld;
        la = w[0*BITS +: BITS];
        lb = w[1*BITS +: BITS];
        lc = w[2*BITS +: BITS];
        ld = w[3*BITS +: BITS];
        p.r  = {ld[1:0], la[5:0]};
        p.g  = {ld[3:2], lb[4:0], la[6]};
        p.b  = {ld[5:4], lc[3:0], lb[6:5]};
        p.hs = lc[4];
        p.vs = lc[5];
        p.de = lc[6];
        return p;
    endfunction

endpackage

// File: rtl/link_deser.sv
module link_deser #(
    parameter int LANES = 4,
    parameter int BITS  = 7
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic [LANES-1:0]      data_i,
    input  logic                  fclk_i,
    output logic                  edge_o,
    output logic                  vld_o,
    output logic [LANES*BITS-1:0] word_o
);
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic             fclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done;

    assign edge_o = fclk_i & ~fclk_q;
    assign done   = !clr_i && !edge_o && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fclk_q <= 1'b0;
            cnt_q  <= '0;
            vld_o  <= 1'b0;
        end else begin
            fclk_q <= fclk_i;
            vld_o  <= done;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (edge_o) begin
                cnt_q <= CNT_W'(1);
            end else if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BITS-1:0] sr_q;
        logic [BITS-1:0] wd_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                sr_q <= '0;
                wd_q <= '0;
            end else begin
                sr_q <= {sr_q[BITS-2:0], data_i[l]};
                if (done) begin
                    wd_q <= {sr_q[BITS-2:0], data_i[l]};
                end
            end
        end
        assign word_o[l*BITS +: BITS] = wd_q;
    end

endmodule

// File: rtl/fs_watch.sv
module fs_watch #(
    parameter int LIMIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    output logic lost_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] TRIP = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] miss_q;

    assign lost_o = !edge_i && (miss_q >= TRIP);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            miss_q <= '0;
        end else if (edge_i) begin
            miss_q <= '0;
        end else if (miss_q != SAT) begin
            miss_q <= miss_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pclk_gen.sv
module pclk_gen #(
    parameter int BITS = 7
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic upd_i,
    input  logic launch_i,
    input  logic single_i,
    output logic pclk_o
);
    localparam int MAXC  = 2 * BITS;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] HALF_DUAL = CNT_W'((BITS + 1) / 2);
    localparam logic [CNT_W-1:0] HALF_SGL  = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] SAT       = CNT_W'(MAXC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] half;

    assign half    = single_i ? HALF_SGL : HALF_DUAL;
    assign cnt_nxt = (cnt_q == SAT) ? cnt_q : cnt_q + CNT_W'(1);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= SAT;
            pclk_o <= 1'b0;
        end else if (upd_i) begin
            cnt_q  <= '0;
            pclk_o <= launch_i;
        end else begin
            cnt_q  <= cnt_nxt;
            pclk_o <= (cnt_nxt < half) ? launch_i : ~launch_i;
        end
    end

endmodule

// File: rtl/pxl_deser.sv
module pxl_deser
    import pxl_deser_pkg::*;
#(
    parameter int MISS_LIMIT = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         mode_i,
    input  logic               edge_sel_i,
    input  logic [LANES-1:0]   l1_data_i,
    input  logic               l1_fclk_i,
    input  logic [LANES-1:0]   l2_data_i,
    input  logic               l2_fclk_i,
    output logic [COLOR_W-1:0] p1_r_o,
    output logic [COLOR_W-1:0] p1_g_o,
    output logic [COLOR_W-1:0] p1_b_o,
    output logic [COLOR_W-1:0] p2_r_o,
    output logic [COLOR_W-1:0] p2_g_o,
    output logic [COLOR_W-1:0] p2_b_o,
    output logic               de_o,
    output logic               hs_o,
    output logic               vs_o,
    output logic               pix_clk_o,
    output logic               pix_stb_o,
    output logic               out_en_o
);
    dsr_state_e        state_q, state_d;
    logic [1:0]        mode_q;
    logic              single, failsafe;
    logic              mode_chg, lost_raw, lost, clr;
    logic              e1, e2, v1, v2, wd_edge;
    logic [WORD_W-1:0] w1, w2;
    pixel_t            px1, px2_new, px2_hold, px2, held_q;
    logic              realign;
    logic              pres_dual, pres_pair, hold_ld;

    assign single   = mode_i[0];
    assign failsafe = mode_i[1];
    assign mode_chg = (mode_i != mode_q);
    assign lost     = failsafe && lost_raw && (state_q != ST_LOST);
    assign clr      = mode_chg || lost;
    assign wd_edge  = e1 || (!single && e2);

    // Two link front ends built from one template
    link_deser #(.LANES(LANES), .BITS(BITS)) u_link1 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .data_i (l1_data_i),
        .fclk_i (l1_fclk_i),
        .edge_o (e1),
        .vld_o  (v1),
        .word_o (w1)
    );

    link_deser #(.LANES(LANES), .BITS(BITS)) u_link2 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .data_i (l2_data_i),
        .fclk_i (l2_fclk_i),
        .edge_o (e2),
        .vld_o  (v2),
        .word_o (w2)
    );

    fs_watch #(.LIMIT(MISS_LIMIT)) u_watch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .edge_i (wd_edge),
        .lost_o (lost_raw)
    );

    pclk_gen #(.BITS(BITS)) u_pclk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .upd_i    (pres_dual || pres_pair),
        .launch_i (edge_sel_i),
        .single_i (single),
        .pclk_o   (pix_clk_o)
    );

    assign px1     = unpack_word(w1);
    assign px2_new = unpack_word(w2);
    assign px2     = v2 ? px2_new : px2_hold;
    assign realign = px1.de && !held_q.de;

    // Next state and the actions it implies
    always_comb begin
        state_d   = state_q;
        pres_dual = 1'b0;
        pres_pair = 1'b0;
        hold_ld   = 1'b0;
        unique case (state_q)
            ST_SYNC, ST_LOST: begin
                if (v1) begin
                    if (single) begin
                        state_d = ST_PAIR_HI;
                        hold_ld = 1'b1;
                    end else begin
                        state_d   = ST_DUAL;
                        pres_dual = 1'b1;
                    end
                end
            end
            ST_DUAL: begin
                pres_dual = v1;
            end
            ST_PAIR_LO: begin
                if (v1) begin
                    state_d = ST_PAIR_HI;
                    hold_ld = 1'b1;
                end
            end
            ST_PAIR_HI: begin
                if (v1) begin
                    if (realign) begin
                        hold_ld = 1'b1;
                    end else begin
                        state_d   = ST_PAIR_LO;
                        pres_pair = 1'b1;
                    end
                end
            end
            default: state_d = ST_SYNC;
        endcase
        if (lost) begin
            state_d   = ST_LOST;
            pres_dual = 1'b0;
            pres_pair = 1'b0;
            hold_ld   = 1'b0;
        end
        if (mode_chg) begin
            state_d   = ST_SYNC;
            pres_dual = 1'b0;
            pres_pair = 1'b0;
            hold_ld   = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_SYNC;
            mode_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p1_r_o    <= '0;
            p1_g_o    <= '0;
            p1_b_o    <= '0;
            p2_r_o    <= '0;
            p2_g_o    <= '0;
            p2_b_o    <= '0;
            de_o      <= 1'b0;
            hs_o      <= 1'b0;
            vs_o      <= 1'b0;
            pix_stb_o <= 1'b0;
            out_en_o  <= 1'b1;
            held_q    <= '0;
            px2_hold  <= '0;
        end else begin
            pix_stb_o <= pres_dual || pres_pair;
            if (v2) begin
                px2_hold <= px2_new;
            end
            if (hold_ld) begin
                held_q <= px1;
            end
            if (pres_dual) begin
                {p1_r_o, p1_g_o, p1_b_o} <= {px1.r, px1.g, px1.b};
                {p2_r_o, p2_g_o, p2_b_o} <= {px2.r, px2.g, px2.b};
                {de_o, vs_o, hs_o}       <= {px1.de, px1.vs, px1.hs};
            end
            if (pres_pair) begin
                {p1_r_o, p1_g_o, p1_b_o} <= {held_q.r, held_q.g, held_q.b};
                {p2_r_o, p2_g_o, p2_b_o} <= {px1.r, px1.g, px1.b};
                {de_o, vs_o, hs_o}       <= {held_q.de, held_q.vs, held_q.hs};
            end
            if (mode_chg) begin
                de_o <= 1'b0;
            end
            if (!failsafe) begin
                out_en_o <= 1'b1;
            end else if (lost) begin
                out_en_o <= 1'b0;
            end else if (v1 && !mode_chg) begin
                out_en_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxl_deser_chk.sv
module pxl_deser_chk #(
    parameter int MISS_LIMIT = 16
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       edge_sel_i,
    input logic       l1_fclk_i,
    input logic       l2_fclk_i,
    input logic [7:0] p1_r_o,
    input logic [7:0] p1_g_o,
    input logic [7:0] p1_b_o,
    input logic [7:0] p2_r_o,
    input logic [7:0] p2_g_o,
    input logic [7:0] p2_b_o,
    input logic       de_o,
    input logic       hs_o,
    input logic       vs_o,
    input logic       pix_clk_o,
    input logic       pix_stb_o,
    input logic       out_en_o
);
    localparam int GAP_W = $clog2(MISS_LIMIT + 8);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MISS_LIMIT + 7);
    localparam logic [GAP_W-1:0] GAP_TRIP = GAP_W'(MISS_LIMIT + 4);

    logic             f1_q, f2_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f1_q  <= 1'b0;
            f2_q  <= 1'b0;
            gap_q <= '0;
        end else begin
            f1_q <= l1_fclk_i;
            f2_q <= l2_fclk_i;
            if ((l1_fclk_i && !f1_q) || (l2_fclk_i && !f2_q)) begin
                gap_q <= '0;
            end else if (gap_q != GAP_SAT) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    // R6
    launch_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_stb_o |-> (pix_clk_o == $past(edge_sel_i)));

    // R7
    hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_stb_o |-> ($stable({p1_r_o, p1_g_o, p1_b_o, p2_r_o, p2_g_o, p2_b_o, hs_o, vs_o})
                        && (!de_o || $stable(de_o))));

    // R8
    mode_de_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != $past(mode_i)) |=> !de_o);

    // R11
    plain_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(mode_i[1]) |-> out_en_o);

    // R9
    failsafe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i[1] && $past(mode_i[1]) && (gap_q >= GAP_TRIP)) |-> !out_en_o);

    // R10
    strobe_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_stb_o |-> out_en_o);

endmodule

bind pxl_deser pxl_deser_chk #(.MISS_LIMIT(MISS_LIMIT)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .edge_sel_i (edge_sel_i),
    .l1_fclk_i  (l1_fclk_i),
    .l2_fclk_i  (l2_fclk_i),
    .p1_r_o     (p1_r_o),
    .p1_g_o     (p1_g_o),
    .p1_b_o     (p1_b_o),
    .p2_r_o     (p2_r_o),
    .p2_g_o     (p2_g_o),
    .p2_b_o     (p2_b_o),
    .de_o       (de_o),
    .hs_o       (hs_o),
    .vs_o       (vs_o),
    .pix_clk_o  (pix_clk_o),
    .pix_stb_o  (pix_stb_o),
    .out_en_o   (out_en_o)
);

// File: tb/pxl_deser_bench.sv
module pxl_deser_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       edge_sel = 1'b1;
    logic [3:0] l1_data = '0, l2_data = '0;
    logic       l1_fclk = 1'b0, l2_fclk = 1'b0;
    logic [7:0] p1_r, p1_g, p1_b, p2_r, p2_g, p2_b;
    logic       de, hs, vs, pix_clk, pix_stb, out_en;

    always #5 clk = ~clk;

    pxl_deser u_pxl_deser (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .edge_sel_i(edge_sel),
        .l1_data_i(l1_data), .l1_fclk_i(l1_fclk), .l2_data_i(l2_data), .l2_fclk_i(l2_fclk),
        .p1_r_o(p1_r), .p1_g_o(p1_g), .p1_b_o(p1_b), .p2_r_o(p2_r), .p2_g_o(p2_g), .p2_b_o(p2_b),
        .de_o(de), .hs_o(hs), .vs_o(vs), .pix_clk_o(pix_clk), .pix_stb_o(pix_stb), .out_en_o(out_en)
    );

    int checks = 0, fails = 0, cyc = 0, gap_mode = 0;
    bit done = 0;
    logic [50:0] exp_q[$];
    logic [26:0] held;
    bit          have_held = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bench pixel: {de, vs, hs, r[7:0], g[7:0], b[7:0]}
    function automatic logic [26:0] rnd_px(input bit d);
        return {d, 2'($urandom), 24'($urandom)};
    endfunction

    // R1 R2: encode a pixel onto four lanes, bit 6 sent first
    task automatic send(input logic [26:0] x, input logic [26:0] y);
        logic [6:0] a1, b1, c1, d1, a2, b2, c2, d2;
        a1 = {x[8], x[21:16]};  b1 = {x[1:0], x[13:9]};
        c1 = {x[26], x[25], x[24], x[5:2]};  d1 = {1'b0, x[7:6], x[15:14], x[23:22]};
        a2 = {y[8], y[21:16]};  b2 = {y[1:0], y[13:9]};
        c2 = {y[26], y[25], y[24], y[5:2]};  d2 = {1'b0, y[7:6], y[15:14], y[23:22]};
        for (int s = 6; s >= 0; s--) begin
            @(negedge clk);
            l1_data = {d1[s], c1[s], b1[s], a1[s]};
            l2_data = {d2[s], c2[s], b2[s], a2[s]};
            l1_fclk = (s >= 3);
            l2_fclk = (s >= 3);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            l1_fclk = 1'b0; l2_fclk = 1'b0;
            l1_data = 4'($urandom); l2_data = 4'($urandom);
        end
    endtask

    // Driver: sends one frame and pushes what the requirements predict
    task automatic frame(input logic [26:0] x, input logic [26:0] y);
        send(x, y);
        if (!mode[0]) begin
            exp_q.push_back({x[26:24], x[23:0], y[23:0]});          // R3
        end else if (!have_held || (x[26] && !held[26])) begin
            held = x; have_held = 1;                                // R5
        end else begin
            exp_q.push_back({held[26:24], held[23:0], x[23:0]});    // R4
            have_held = 0;
        end
    endtask

    // Monitor / scoreboard
    logic [50:0] last_out;
    logic        prev_pclk;
    int          last_stb = 0;
    bit          have_last = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic [50:0] got = {de, vs, hs, p1_r, p1_g, p1_b, p2_r, p2_g, p2_b};
            automatic string tag = mode[0] ? "R4" : "R3";
            if (pix_stb) begin
                if (exp_q.size() == 0) begin
                    chk(0, tag, "unexpected strobe", got, 0);
                end else begin
                    automatic logic [50:0] e = exp_q.pop_front();
                    chk(got === e, tag, "R1/R2 word", got, e);
                end
                chk(pix_clk == edge_sel, "R6", "pclk at strobe", pix_clk, edge_sel);
                chk(prev_pclk == !edge_sel, "R6", "pclk before strobe", prev_pclk, !edge_sel);
                if (gap_mode != 0 && have_last)
                    chk(cyc - last_stb == gap_mode, tag, "strobe spacing", cyc - last_stb, gap_mode);
                have_last = (gap_mode != 0);
                last_stb = cyc;
            end else if (cyc > 8) begin
                chk((got[47:0] === last_out[47:0]) && (got[50] == last_out[50] || !got[50]),
                    "R7", "hold between strobes", got, last_out);
            end
            last_out = got;
            prev_pclk = pix_clk;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        chk({de, pix_stb, out_en} == 3'b001, "R12", "reset ctrl", {de, pix_stb, out_en}, 3'b001);
        chk({p1_r, p1_g, p1_b, p2_r, p2_g, p2_b} == '0, "R12", "reset data", p1_r, 0);

        // Dual link, rising launch
        idle(3);
        frame({3'b100, 24'hFFFFFF}, {3'b000, 24'h000000});
        gap_mode = 7;
        frame({3'b111, 24'h000000}, {3'b111, 24'hFFFFFF});
        frame({3'b110, 24'h814281}, {3'b001, 24'h7EBD7E});
        for (int i = 0; i < 5; i++) frame(rnd_px(1), rnd_px($urandom_range(0, 1)));
        gap_mode = 0;
        idle(30);
        chk(out_en == 1'b1, "R11", "enable with no frames in plain mode", out_en, 1);

        // Mode change to single link, falling launch
        chk(de == 1'b1, "R8", "de before mode change", de, 1);
        mode = 2'b01; have_held = 0;
        @(negedge clk);
        chk(de == 1'b0, "R8", "de after mode change", de, 0);
        edge_sel = 1'b0;
        idle(2);
        frame(rnd_px(1), rnd_px(1));
        gap_mode = 14;
        for (int i = 0; i < 7; i++) frame(rnd_px(1), rnd_px($urandom_range(0, 1)));
        gap_mode = 0;
        // R5 realignment on DE rise
        frame(rnd_px(0), rnd_px(1));
        frame(rnd_px(0), rnd_px(1));
        frame(rnd_px(0), rnd_px(0));
        for (int i = 0; i < 4; i++) frame(rnd_px(1), rnd_px(0));
        idle(3);

        // Dual link with fail-safe
        mode = 2'b10; have_held = 0;
        @(negedge clk);
        chk(de == 1'b0, "R8", "de after second mode change", de, 0);
        edge_sel = 1'b1;
        idle(2);
        for (int i = 0; i < 3; i++) frame(rnd_px(1), rnd_px(1));
        idle(5);
        chk(out_en == 1'b1, "R9", "enable before gap limit", out_en, 1);
        idle(20);
        chk(out_en == 1'b0, "R9", "enable after long gap", out_en, 0);
        have_held = 0;
        frame(rnd_px(1), rnd_px(0));
        idle(3);
        chk(out_en == 1'b1, "R10", "enable after resume", out_en, 1);
        frame(rnd_px(1), rnd_px(1));
        idle(3);

        // Single link with fail-safe
        mode = 2'b11; have_held = 0;
        idle(3);
        for (int i = 0; i < 4; i++) frame(rnd_px(1), rnd_px(1));
        idle(25);
        chk(out_en == 1'b0, "R9", "single-link enable after gap", out_en, 0);
        have_held = 0;
        frame(rnd_px(1), rnd_px(0));
        frame(rnd_px(1), rnd_px(0));
        idle(5);
        chk(out_en == 1'b1, "R10", "single-link enable after resume", out_en, 1);
        chk(exp_q.size() == 0, "R4", "words left unpresented", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule